// File: doc/BRIEF.md
# HDLC Frame Receiver with Error Closure and Hunt Recovery

This block is the receive half of a bit-oriented HDLC channel. A bit stream arrives one bit per `bit_en` strobe, together with a carrier-detect level. The receiver first looks for an opening flag. It then strips the zeros that the transmitter inserted, assembles the data bits into bytes and places them in a small receive FIFO that a consumer drains with `rd_en`.

Every frame ends in one of two ways. A closing flag ends it normally, and the CRC and bit-count checks are then reported. An error also ends it: carrier loss, FIFO overrun or an abort sequence. Each of these errors closes the frame with a single cause bit and sends the receiver back to hunting for a flag. Causes are resolved in a fixed order, so a frame never reports more than one of them. Abort sequences that close a frame are tallied in a saturating counter.

Top module: `hdlc_rx`

## Requirements
- R1: After reset and after every error closure, the receiver hunts. Until it sees the flag bit pattern 0,1,1,1,1,1,1,0, it writes no byte and reports no status.
- R2: A zero that arrives right after five consecutive ones is deleted from the data stream. It counts neither as a data bit nor toward the bit count.
- R3: Data bits are packed first-received into bit 0 and written to a two-entry FIFO. `rd_valid` is high while the FIFO holds data, `rd_data` shows the oldest entry, and `rd_en` removes it. Bytes leave in arrival order.
- R4: A closing flag after at least one data bit raises `stat_valid` for one cycle. The strobe that completes the flag is sampled at a clock edge, and the pulse appears in the cycle after that edge. `stat_crc_err` is set unless the CRC-16 register (reflected polynomial 0x8408, preset 0xFFFF, fed with every data bit including the check bytes) equals 0xF0B8.
- R5: On the same closing flag, `stat_non_octet` is set when the number of data bits is not a multiple of 8.
- R6: When a byte completes while the FIFO holds two entries and no read happens, the new byte replaces the most recently stored entry. The frame closes with `stat_overrun` as its only status bit, and the receiver hunts.
- R7: If `cd` is low while a frame is open and `cd_sw` is low, the frame closes with `stat_cd_lost` as its only status bit and the receiver hunts. Carrier loss outranks every other cause. An abort on that same bit strobe is neither reported nor counted.
- R8: While `cd_sw` is high, `cd` has no effect on reception.
- R9: The seventh consecutive one in an open frame that holds at least one data bit closes it with `stat_abort` only. No CRC or non-octet result is given for that frame, `abort_count` increments (saturating) and the receiver hunts. An abort before any data bit is silent and uncounted.
- R10: After reset the FIFO is empty, `stat_valid` is low and `abort_count` is zero. A flag with no data bits since the previous flag reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe: `rx_bit` is valid this cycle |
| rx_bit | input | 1 | Serial receive bit |
| cd | input | 1 | Carrier detect, high while carrier is present |
| cd_sw | input | 1 | High: carrier detect is managed elsewhere and is ignored |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | DATA_W | Oldest FIFO byte |
| rd_valid | output | 1 | FIFO is not empty |
| stat_valid | output | 1 | One-cycle pulse: a frame has closed |
| stat_overrun | output | 1 | Frame closed by FIFO overrun |
| stat_cd_lost | output | 1 | Frame closed by carrier loss |
| stat_abort | output | 1 | Frame closed by abort sequence |
| stat_crc_err | output | 1 | CRC residue mismatch on a flag-closed frame |
| stat_non_octet | output | 1 | Bit count not a multiple of 8 on a flag-closed frame |
| abort_count | output | CNT_W | Saturating count of reported aborts |

## Verification
Every result depends on a single clock edge. A closing flag, an abort bit, an overrunning bit or a carrier drop is sampled at one edge, and the status pulse and the FIFO change appear right after that edge. The driver records the cycle number in which each status is due when it drives the deciding bit. The monitor compares both the cause bits and the cycle in which `stat_valid` is high. Bytes come out seven data bits after their final bit because of the flag look-behind, so the FIFO is checked by order only.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int STUFF_RUN = 5;
  localparam int FLAG_RUN  = 6;
  localparam int ABORT_RUN = 7;
  localparam int FLAG_BITS = 8;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RF = 16'h8408;
  localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

  typedef enum logic {RX_HUNT, RX_OPEN} rx_mode_e;
endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic carrier_ok,
  input  logic force_hunt,
  output logic in_frame,
  output logic emit_v,
  output logic emit_b,
  output logic flag_ev,
  output logic abort_ev
);
  localparam int LD = FLAG_BITS - 1;
  localparam int OW = $clog2(ABORT_RUN + 1);

  rx_mode_e        mode_q;
  logic [OW-1:0]   run_q;
  logic [LD-1:0]   dly_b;
  logic [LD-1:0]   dly_v;
  logic            strobe, is_flag, is_stuff, is_abort, push;

  assign strobe   = bit_en & carrier_ok;
  assign is_flag  = strobe & ~rx_bit & (run_q == OW'(FLAG_RUN));
  assign is_stuff = strobe & ~rx_bit & (run_q == OW'(STUFF_RUN));
  assign is_abort = strobe &  rx_bit & (run_q == OW'(ABORT_RUN - 1));
  assign push     = strobe & ~is_flag & ~is_stuff & ~is_abort;

  assign in_frame = (mode_q == RX_OPEN);
  assign emit_v   = push & in_frame & dly_v[LD-1];
  assign emit_b   = dly_b[LD-1];
  assign flag_ev  = is_flag & in_frame;
  assign abort_ev = is_abort & in_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RX_HUNT;
      run_q  <= '0;
      dly_b  <= '0;
      dly_v  <= '0;
    end else begin
      if (!carrier_ok)
        run_q <= '0;
      else if (bit_en)
        run_q <= rx_bit ? ((run_q == OW'(ABORT_RUN)) ? run_q : run_q + 1'b1) : '0;

      if (force_hunt || abort_ev) begin
        mode_q <= RX_HUNT;
        dly_v  <= '0;
      end else if (is_flag) begin
        mode_q <= RX_OPEN;
        dly_v  <= '0;
      end else if (push) begin
        dly_b <= {dly_b[LD-2:0], rx_bit};
        dly_v <= {dly_v[LD-2:0], in_frame};
      end
    end
  end

  // Stuffed zeros never advance the delay line (R2)
  assert_stuff_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    is_stuff |=> ($stable(dly_b) && $stable(dly_v)));
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_v,
  input  logic bit_d,
  output logic crc_ok
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb     = crc_q[0] ^ bit_d;
  assign crc_ok = (crc_q == CRC_GOOD);

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc_q <= CRC_PRESET;
    else if (bit_v)
      crc_q <= (crc_q >> 1) ^ (fb ? CRC_POLY_RF : 16'h0000);
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, last_p;
  logic [CW-1:0] cnt_q;
  logic          full, do_rd, do_wr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign do_rd    = rd_en & (cnt_q != '0);
  assign ovr      = wr_en & full & ~do_rd;
  assign do_wr    = wr_en & ~ovr;
  assign last_p   = (wp_q == '0) ? AW'(DEPTH - 1) : wp_q - 1'b1;
  assign rd_data  = mem[rp_q];
  assign rd_valid = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (do_wr)
      mem[wp_q] <= wr_data;
    else if (ovr)
      mem[last_p] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= step(wp_q);
      if (do_rd) rp_q <= step(rp_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_overwrite_stays_full_R6: assert property (@(posedge clk) disable iff (rst)
    ovr |=> rd_valid && (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              cd,
  input  logic              cd_sw,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              stat_valid,
  output logic              stat_overrun,
  output logic              stat_cd_lost,
  output logic              stat_abort,
  output logic              stat_crc_err,
  output logic              stat_non_octet,
  output logic [CNT_W-1:0]  abort_count
);
  localparam int IW = $clog2(DATA_W);

  logic              carrier_ok, cd_lost, force_hunt;
  logic              in_frame, emit_v, emit_b, flag_ev, abort_ev;
  logic              wr_en, ovr, crc_ok, crc_clr;
  logic [DATA_W-1:0] sr_q, wr_data;
  logic [IW-1:0]     idx_q;
  logic              started_q;
  logic              close_cd, close_ovr, close_abt, close_flag;

  assign carrier_ok = cd | cd_sw;
  assign cd_lost    = in_frame & ~carrier_ok;
  assign force_hunt = cd_lost | ovr;
  assign wr_en      = emit_v & (idx_q == IW'(DATA_W - 1));
  assign wr_data    = {emit_b, sr_q[DATA_W-1:1]};
  assign crc_clr    = ~in_frame | flag_ev;

  // cause priority: carrier loss, then overrun, then abort, then flag close
  assign close_cd   = cd_lost & started_q;
  assign close_ovr  = ovr & ~close_cd;
  assign close_abt  = abort_ev & started_q & ~close_cd & ~close_ovr;
  assign close_flag = flag_ev & started_q & ~close_cd & ~close_ovr & ~close_abt;

  hdlc_rx_deframe u_deframe (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .carrier_ok (carrier_ok),
    .force_hunt (force_hunt),
    .in_frame   (in_frame),
    .emit_v     (emit_v),
    .emit_b     (emit_b),
    .flag_ev    (flag_ev),
    .abort_ev   (abort_ev)
  );

  hdlc_rx_crc u_crc (
    .clk    (clk),
    .rst    (rst),
    .clr    (crc_clr),
    .bit_v  (emit_v),
    .bit_d  (emit_b),
    .crc_ok (crc_ok)
  );

  hdlc_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ovr      (ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q           <= '0;
      idx_q          <= '0;
      started_q      <= 1'b0;
      stat_valid     <= 1'b0;
      stat_overrun   <= 1'b0;
      stat_cd_lost   <= 1'b0;
      stat_abort     <= 1'b0;
      stat_crc_err   <= 1'b0;
      stat_non_octet <= 1'b0;
      abort_count    <= '0;
    end else begin
      stat_valid     <= close_cd | close_ovr | close_abt | close_flag;
      stat_cd_lost   <= close_cd;
      stat_overrun   <= close_ovr;
      stat_abort     <= close_abt;
      stat_crc_err   <= close_flag & ~crc_ok;
      stat_non_octet <= close_flag & (idx_q != '0);
      if (close_abt && abort_count != {CNT_W{1'b1}})
        abort_count <= abort_count + 1'b1;

      if (!in_frame || flag_ev || abort_ev || force_hunt) begin
        idx_q     <= '0;
        started_q <= 1'b0;
      end else if (emit_v) begin
        sr_q      <= wr_data;
        idx_q     <= (idx_q == IW'(DATA_W - 1)) ? '0 : idx_q + 1'b1;
        started_q <= 1'b1;
      end
    end
  end

  assert_hunt_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    !in_frame |-> !wr_en);
  assert_single_cause_R7: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $onehot0({stat_overrun, stat_cd_lost, stat_abort}));
  assert_carrier_loss_hunts_R7: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !cd && !cd_sw) |=> !in_frame);
  assert_abort_unchecked_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_abort) |-> (!stat_crc_err && !stat_non_octet));
  assert_abort_counts_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_abort && $past(abort_count) != {CNT_W{1'b1}})
      |-> abort_count == $past(abort_count) + 1'b1);
endmodule

// File: tb/hdlc_rx_tb_top.sv
module hdlc_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, rx_bit = 1'b1, cd = 1'b1, cd_sw = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, stat_valid, stat_overrun, stat_cd_lost, stat_abort;
  logic       stat_crc_err, stat_non_octet;
  logic [15:0] abort_count;

  always #5 clk = ~clk;

  hdlc_rx dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .cd(cd), .cd_sw(cd_sw),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .stat_valid(stat_valid),
    .stat_overrun(stat_overrun), .stat_cd_lost(stat_cd_lost), .stat_abort(stat_abort),
    .stat_crc_err(stat_crc_err), .stat_non_octet(stat_non_octet), .abort_count(abort_count)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit drain = 1'b1;
  logic [7:0] q_byte[$];
  logic [4:0] q_st[$];
  int         q_cyc[$];
  string      q_tag[$];
  logic [15:0] bcrc;
  int bbits, tones;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: status pulses by cause and cycle, FIFO bytes by order
  always @(negedge clk) begin
    if (!rst && stat_valid) begin
      if (q_st.size() == 0)
        chk(1'b0, "R10", "unexpected status", {stat_overrun, stat_cd_lost, stat_abort, stat_crc_err, stat_non_octet}, 0);
      else begin
        chk({stat_overrun, stat_cd_lost, stat_abort, stat_crc_err, stat_non_octet} == q_st[0],
            q_tag[0], "status bits", {stat_overrun, stat_cd_lost, stat_abort, stat_crc_err, stat_non_octet}, q_st[0]);
        chk(cyc == q_cyc[0], q_tag[0], "status cycle", cyc, q_cyc[0]);
        void'(q_st.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
    if (!rst && drain && rd_valid) begin
      if (q_byte.size() == 0)
        chk(1'b0, "R3", "unexpected byte", rd_data, 0);
      else begin
        chk(rd_data == q_byte[0], "R3", "fifo byte", rd_data, q_byte[0]);
        void'(q_byte.pop_front());
      end
      rd_en = 1'b1;
    end else
      rd_en = 1'b0;
  end

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = c >> 1;
    if (c[0] ^ b) s = s ^ 16'h8408;
    return s;
  endfunction

  task automatic send_bit(input bit b, input bit cdv, input bit ex, input logic [4:0] eb, input string tag);
    @(negedge clk);
    if (ex) begin q_st.push_back(eb); q_cyc.push_back(cyc + 1); q_tag.push_back(tag); end
    bit_en = 1'b1; rx_bit = b; cd = cdv;
    @(negedge clk);
    bit_en = 1'b0; cd = 1'b1;
  endtask

  task automatic raw(input bit b);
    send_bit(b, 1'b1, 1'b0, 5'd0, "");
  endtask

  task automatic dbit(input bit b, input bit ex, input logic [4:0] eb, input string tag);
    send_bit(b, 1'b1, ex, eb, tag);
    bcrc = crc_step(bcrc, b);
    bbits++;
    if (b) begin
      tones++;
      if (tones == 5) begin raw(1'b0); tones = 0; end
    end else tones = 0;
  endtask

  task automatic dbyte(input logic [7:0] v, input bit expect_out);
    if (expect_out) q_byte.push_back(v);
    for (int i = 0; i < 8; i++) dbit(v[i], 1'b0, 5'd0, "");
  endtask

  task automatic flag_open;
    raw(1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    raw(1'b0);
    bcrc = 16'hFFFF; bbits = 0; tones = 0;
  endtask

  task automatic flag_close(input string tag);
    raw(1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    send_bit(1'b0, 1'b1, 1'b1, {3'b000, bcrc != 16'hF0B8, (bbits % 8) != 0}, tag);
    bcrc = 16'hFFFF; bbits = 0; tones = 0;
  endtask

  task automatic fcs(input bit corrupt);
    logic [15:0] f;
    f = ~bcrc;
    if (corrupt) f[0] = ~f[0];
    dbyte(f[7:0], 1'b1);
    dbyte(f[15:8], 1'b1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(rd_valid == 1'b0, "R10", "rd_valid after reset", rd_valid, 0);
    chk(stat_valid == 1'b0, "R10", "stat_valid after reset", stat_valid, 0);
    chk(abort_count == 16'd0, "R10", "abort_count after reset", abort_count, 0);

    // R1: noise while hunting, including seven ones, gives nothing
    for (int i = 0; i < 24; i++) raw((i % 3) != 0);
    for (int i = 0; i < 8; i++) raw(1'b1);
    raw(1'b0);
    idle(4);
    chk(rd_valid == 1'b0, "R1", "no byte while hunting", rd_valid, 0);
    chk(abort_count == 16'd0, "R1", "no abort while hunting", abort_count, 0);

    // R2 R3 R4: good frame whose data forces zero removal
    flag_open();
    dbyte(8'h12, 1'b1); dbyte(8'hFF, 1'b1); dbyte(8'h7E, 1'b1);
    fcs(1'b0);
    flag_close("R4");
    // R10: flag right after a flag reports nothing; R4 bad check bytes
    flag_open();
    dbyte(8'h3F, 1'b1); dbyte(8'hF8, 1'b1);
    fcs(1'b1);
    flag_close("R4");
    // R5: three extra bits after the check bytes
    flag_open();
    dbyte(8'hA5, 1'b1);
    fcs(1'b0);
    dbit(1'b1, 1'b0, 5'd0, ""); dbit(1'b0, 1'b0, 5'd0, ""); dbit(1'b1, 1'b0, 5'd0, "");
    flag_close("R5");
    idle(10);

    // R9: abort with data; only the first byte has left the look-behind
    flag_open();
    dbyte(8'h55, 1'b1); dbyte(8'h66, 1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    send_bit(1'b1, 1'b1, 1'b1, 5'b00100, "R9");
    for (int i = 0; i < 5; i++) raw(1'b1);
    idle(3);
    chk(abort_count == 16'd1, "R9", "abort counted", abort_count, 1);
    // R9: abort right after a flag is silent
    flag_open();
    for (int i = 0; i < 8; i++) raw(1'b1);
    idle(3);
    chk(abort_count == 16'd1, "R9", "empty abort not counted", abort_count, 1);
    idle(10);
    chk(q_byte.size() == 0, "R3", "bytes drained", q_byte.size(), 0);

    // R6: overrun with reads held off; third byte overwrites the second
    drain = 1'b0;
    flag_open();
    dbyte(8'hA1, 1'b0); dbyte(8'hB2, 1'b0); dbyte(8'hC3, 1'b0);
    for (int i = 0; i < 6; i++) dbit(((8'hD4 >> i) & 1) != 0, 1'b0, 5'd0, "");
    dbit(1'b1, 1'b1, 5'b10000, "R6");
    dbit(1'b1, 1'b0, 5'd0, "");
    flag_close("R6"); void'(q_st.pop_back()); void'(q_cyc.pop_back()); void'(q_tag.pop_back());
    idle(4);
    chk(rd_valid == 1'b1, "R6", "fifo holds data", rd_valid, 1);
    chk(rd_data == 8'hA1, "R6", "oldest entry kept", rd_data, 8'hA1);
    q_byte.push_back(8'hA1); q_byte.push_back(8'hC3);
    drain = 1'b1;
    idle(6);
    chk(q_byte.size() == 0 && !rd_valid, "R6", "fifo drained to two bytes", q_byte.size(), 0);

    // R7: carrier drop mid frame
    flag_open();
    dbyte(8'h11, 1'b1); dbyte(8'h22, 1'b0);
    for (int i = 0; i < 4; i++) dbit(((8'h33 >> i) & 1) != 0, 1'b0, 5'd0, "");
    @(negedge clk);
    q_st.push_back(5'b01000); q_cyc.push_back(cyc + 1); q_tag.push_back("R7");
    cd = 1'b0;
    @(negedge clk);
    cd = 1'b1;
    for (int i = 0; i < 8; i++) raw(1'b0);
    idle(4);
    // R7: carrier drop on the same strobe as the seventh one
    flag_open();
    dbyte(8'h44, 1'b1); dbyte(8'h08, 1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    send_bit(1'b1, 1'b0, 1'b1, 5'b01000, "R7");
    idle(4);
    chk(abort_count == 16'd1, "R7", "abort under carrier loss not counted", abort_count, 1);

    // R8: carrier ignored while cd_sw is high
    cd_sw = 1'b1;
    flag_open();
    dbyte(8'h5A, 1'b1);
    @(negedge clk); cd = 1'b0;
    @(negedge clk); @(negedge clk); cd = 1'b1;
    fcs(1'b0);
    flag_close("R8");
    idle(12);
    cd_sw = 1'b0;

    chk(q_st.size() == 0, "R4", "all statuses seen", q_st.size(), 0);
    chk(q_byte.size() == 0, "R3", "all bytes seen", q_byte.size(), 0);
    chk(abort_count == 16'd1, "R9", "final abort count", abort_count, 1);
    finish_run();
  end
endmodule